// File: doc/BRIEF.md
# Opcode Decode and Execute Unit

This block turns a 4-bit enumerated opcode for a small load/store register machine into the datapath steering bits. It picks an ALU function from those bits and the opcode, then computes a result and a zero flag on two operands. It has no clock or state. An opcode change reaches every output through combinational logic alone.

The surrounding datapath uses the steering bits as follows. The register-file read selector is `reg2loc_o`. Memory accesses use `mem_rd_o` and `mem_wr_o`, and write-back uses `mem_to_reg_o` and `reg_wr_o`. The immediate-operand select is `alu_src_o`. Next-address logic uses `branch_o` and `uncond_o`. The two-bit ALU class is `alu_op_o`, and the chosen function code is `fn_code_o`, which is brought out for the execute stage. The datapath supplies the two operands, already selected, on `opnd_a_i` and `opnd_b_i`.

The parameter `DATA_W` sets the operand width. The parameter `SHARED_ADDER` chooses how addition and subtraction are built: one adder with operand inversion, or two separate adders.

Top module: `mdec_ctl_alu_unit`

## Requirements
- R1: Opcodes are coded ADD=0, SUB=1, AND=2, ORR=3, ADDI=4, SUBI=5, LDUR=6, STUR=7, CBZ=8, B=9. For ADD, SUB, AND and ORR, `reg_wr_o`=1 and `alu_op_o`=2'b10, and every other steering bit is 0.
- R2: LDUR and STUR give `alu_src_o`=1, `mem_to_reg_o`=1, `reg_wr_o`=1 and `alu_op_o`=2'b00. LDUR adds `mem_rd_o`=1. STUR adds `mem_wr_o`=1 and `reg2loc_o`=1. `mem_rd_o` and `mem_wr_o` are never both 1.
- R3: ADDI and SUBI give `reg_wr_o`=1, `alu_src_o`=1 and `alu_op_o`=2'b10, and every other steering bit is 0.
- R4: CBZ and B give `branch_o`=1, `alu_src_o`=1 and `alu_op_o`=2'b01. B alone also gives `uncond_o`=1. CBZ alone also gives `reg2loc_o`=1.
- R5: Opcodes 10 to 15 drive every steering bit to 0, including `alu_op_o`=2'b00, and therefore give function code 0.
- R6: Function codes are add=0, subtract=1, pass=2, zero test=3, AND=4, OR=5. ALU class 00 selects 0. Class 01 selects 2 for B and 3 for CBZ. Class 10 selects 0 for ADD and ADDI, 1 for SUB and SUBI, 4 for AND and 5 for ORR.
- R7: Code 0 gives a+b and code 1 gives a−b, both wrapping modulo 2^DATA_W.
- R8: Code 2 gives a unchanged, code 4 gives a AND b, and code 5 gives a OR b.
- R9: Code 3 gives a result of 0, and `zero_o`=1 exactly when a is 0.
- R10: `zero_o` is 0 under every function code other than 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 4 | Enumerated opcode |
| opnd_a_i | input | DATA_W | First operand (a) |
| opnd_b_i | input | DATA_W | Second operand (b) |
| reg2loc_o | output | 1 | Second read port addresses the Rt field |
| branch_o | output | 1 | Branch-class instruction |
| mem_rd_o | output | 1 | Data memory read |
| mem_to_reg_o | output | 1 | Write-back from memory |
| alu_op_o | output | 2 | ALU class |
| mem_wr_o | output | 1 | Data memory write |
| alu_src_o | output | 1 | Second operand comes from the immediate |
| reg_wr_o | output | 1 | Register file write |
| uncond_o | output | 1 | Unconditional branch |
| fn_code_o | output | 3 | Selected ALU function code |
| result_o | output | DATA_W | ALU result |
| zero_o | output | 1 | Zero-test flag |

## Verification
The bench builds two copies at `DATA_W`=64: `u_dut` with `SHARED_ADDER`=1 and `u_dut_sep` with `SHARED_ADDER`=0. Both receive the same stimulus, so each adder variant is checked against the same expected values. At the full 64-bit width, carry and borrow wrap at bit 63 can be reached with all-ones and zero operands. Random 64-bit operands across all sixteen opcode values, including the six unused ones, cover the rest of the steering and function space.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

   typedef enum logic [3:0] {
      OPC_ADD  = 4'd0,
      OPC_SUB  = 4'd1,
      OPC_AND  = 4'd2,
      OPC_ORR  = 4'd3,
      OPC_ADDI = 4'd4,
      OPC_SUBI = 4'd5,
      OPC_LDUR = 4'd6,
      OPC_STUR = 4'd7,
      OPC_CBZ  = 4'd8,
      OPC_B    = 4'd9
   } opc_e;

   typedef enum logic [2:0] {
      FN_ADD   = 3'd0,
      FN_SUB   = 3'd1,
      FN_PASS  = 3'd2,
      FN_ZTEST = 3'd3,
      FN_AND   = 3'd4,
      FN_OR    = 3'd5
   } fn_e;

   localparam logic [1:0] AOP_MEM = 2'b00;
   localparam logic [1:0] AOP_BR  = 2'b01;
   localparam logic [1:0] AOP_ARI = 2'b10;

   typedef struct packed {
      logic       reg2loc;
      logic       branch;
      logic       mem_rd;
      logic       mem_to_reg;
      logic [1:0] alu_op;
      logic       mem_wr;
      logic       alu_src;
      logic       reg_wr;
      logic       uncond;
   } ctl_t;

endpackage

// File: rtl/mdec_main_ctl.sv
module mdec_main_ctl
   import mdec_pkg::*;
(
   input  opc_e opc_i,
   output ctl_t ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (opc_i)
         OPC_ADD, OPC_SUB, OPC_AND, OPC_ORR: begin
            ctl_o.reg_wr = 1'b1;
            ctl_o.alu_op = AOP_ARI;
         end
         OPC_LDUR, OPC_STUR: begin
            ctl_o.alu_src    = 1'b1;
            ctl_o.mem_to_reg = 1'b1;
            ctl_o.reg_wr     = 1'b1;
            ctl_o.alu_op     = AOP_MEM;
            ctl_o.mem_rd     = (opc_i == OPC_LDUR);
            ctl_o.mem_wr     = (opc_i == OPC_STUR);
            ctl_o.reg2loc    = (opc_i == OPC_STUR);
         end
         OPC_ADDI, OPC_SUBI: begin
            ctl_o.reg_wr  = 1'b1;
            ctl_o.alu_src = 1'b1;
            ctl_o.alu_op  = AOP_ARI;
         end
         OPC_CBZ, OPC_B: begin
            ctl_o.alu_op  = AOP_BR;
            ctl_o.branch  = 1'b1;
            ctl_o.alu_src = 1'b1;
            ctl_o.uncond  = (opc_i == OPC_B);
            ctl_o.reg2loc = (opc_i == OPC_CBZ);
         end
         default: ctl_o = '0;
      endcase
   end

   always_comb begin
      assert_no_rd_wr_clash_R2: assert (!(ctl_o.mem_rd && ctl_o.mem_wr))
         else $error("memory read and write both asserted");
      assert_uncond_is_branch_R4: assert (!ctl_o.uncond || ctl_o.branch)
         else $error("unconditional flag without branch");
   end

endmodule

// File: rtl/mdec_fn_sel.sv
module mdec_fn_sel
   import mdec_pkg::*;
(
   input  logic [1:0] alu_op_i,
   input  opc_e       opc_i,
   output fn_e        fn_o
);

   always_comb begin
      fn_o = FN_ADD;
      case (alu_op_i)
         AOP_MEM: fn_o = FN_ADD;
         AOP_BR: begin
            if (opc_i == OPC_B)        fn_o = FN_PASS;
            else if (opc_i == OPC_CBZ) fn_o = FN_ZTEST;
            else                       fn_o = FN_ADD;
         end
         AOP_ARI: begin
            case (opc_i)
               OPC_ADD, OPC_ADDI: fn_o = FN_ADD;
               OPC_SUB, OPC_SUBI: fn_o = FN_SUB;
               OPC_AND:           fn_o = FN_AND;
               OPC_ORR:           fn_o = FN_OR;
               default:           fn_o = FN_ADD;
            endcase
         end
         default: fn_o = FN_ADD;
      endcase
   end

endmodule

// File: rtl/mdec_alu.sv
module mdec_alu
   import mdec_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  fn_e               fn_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o,
   output logic              zero_o
);

   localparam logic [DATA_W-1:0] ALL_ZERO = '0;

   logic [DATA_W-1:0] add_res;
   logic [DATA_W-1:0] sub_res;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic              do_sub;
         logic [DATA_W-1:0] b_eff;
         logic [DATA_W-1:0] sum;
         assign do_sub  = (fn_i == FN_SUB);
         assign b_eff   = do_sub ? ~b_i : b_i;
         assign sum     = a_i + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
         assign add_res = sum;
         assign sub_res = sum;
      end else begin : g_split
         assign add_res = a_i + b_i;
         assign sub_res = a_i - b_i;
      end
   endgenerate

   always_comb begin
      res_o  = ALL_ZERO;
      zero_o = 1'b0;
      case (fn_i)
         FN_ADD:   res_o = add_res;
         FN_SUB:   res_o = sub_res;
         FN_PASS:  res_o = a_i;
         FN_ZTEST: zero_o = (a_i == ALL_ZERO);
         FN_AND:   res_o = a_i & b_i;
         FN_OR:    res_o = a_i | b_i;
         default:  res_o = ALL_ZERO;
      endcase
   end

endmodule

// File: rtl/mdec_ctl_alu_unit.sv
module mdec_ctl_alu_unit
   import mdec_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [3:0]        opcode_i,
   input  logic [DATA_W-1:0] opnd_a_i,
   input  logic [DATA_W-1:0] opnd_b_i,
   output logic              reg2loc_o,
   output logic              branch_o,
   output logic              mem_rd_o,
   output logic              mem_to_reg_o,
   output logic [1:0]        alu_op_o,
   output logic              mem_wr_o,
   output logic              alu_src_o,
   output logic              reg_wr_o,
   output logic              uncond_o,
   output logic [2:0]        fn_code_o,
   output logic [DATA_W-1:0] result_o,
   output logic              zero_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if ($bits(opc_e) != 4) begin : g_bad_opc
         $error("opcode enumeration must be 4 bits wide");
      end
   endgenerate

   opc_e opc;
   ctl_t ctl;
   fn_e  fn;

   assign opc = opc_e'(opcode_i);

   mdec_main_ctl u_main_ctl (
      .opc_i (opc),
      .ctl_o (ctl)
   );

   mdec_fn_sel u_fn_sel (
      .alu_op_i (ctl.alu_op),
      .opc_i    (opc),
      .fn_o     (fn)
   );

   mdec_alu #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .fn_i   (fn),
      .a_i    (opnd_a_i),
      .b_i    (opnd_b_i),
      .res_o  (result_o),
      .zero_o (zero_o)
   );

   assign reg2loc_o    = ctl.reg2loc;
   assign branch_o     = ctl.branch;
   assign mem_rd_o     = ctl.mem_rd;
   assign mem_to_reg_o = ctl.mem_to_reg;
   assign alu_op_o     = ctl.alu_op;
   assign mem_wr_o     = ctl.mem_wr;
   assign alu_src_o    = ctl.alu_src;
   assign reg_wr_o     = ctl.reg_wr;
   assign uncond_o     = ctl.uncond;
   assign fn_code_o    = fn;

   always_comb begin
      assert_zero_only_ztest_R10: assert (!zero_o || fn_code_o == 3'd3)
         else $error("zero flag outside zero-test");
      assert_ztest_result_R9: assert (fn_code_o != 3'd3 || result_o == '0)
         else $error("nonzero result under zero-test");
      assert_zero_needs_a_zero_R9: assert (!zero_o || opnd_a_i == '0)
         else $error("zero flag with nonzero operand");
      assert_pass_is_uncond_R6: assert ((fn_code_o == 3'd2) == uncond_o)
         else $error("pass function and unconditional flag disagree");
      assert_unused_opc_idle_R5: assert (opcode_i < 4'd10 || (!reg_wr_o && !branch_o && alu_op_o == 2'b00))
         else $error("unused opcode raised a control bit");
   end

endmodule

// File: tb/mdec_ctl_alu_unit_tb.sv
module mdec_ctl_alu_unit_tb;

   localparam int W = 64;

   logic         clk = 1'b0;
   logic [3:0]   opc;
   logic [W-1:0] a, b;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           done = 1'b0;

   always #5 clk = ~clk;

   logic          r2l_0, br_0, mrd_0, m2r_0, mwr_0, src_0, rw_0, un_0, z_0;
   logic [1:0]    aop_0;
   logic [2:0]    fn_0;
   logic [W-1:0]  res_0;
   logic          r2l_1, br_1, mrd_1, m2r_1, mwr_1, src_1, rw_1, un_1, z_1;
   logic [1:0]    aop_1;
   logic [2:0]    fn_1;
   logic [W-1:0]  res_1;

   mdec_ctl_alu_unit #(.DATA_W(W), .SHARED_ADDER(1'b1)) u_dut (
      .opcode_i(opc), .opnd_a_i(a), .opnd_b_i(b),
      .reg2loc_o(r2l_0), .branch_o(br_0), .mem_rd_o(mrd_0), .mem_to_reg_o(m2r_0),
      .alu_op_o(aop_0), .mem_wr_o(mwr_0), .alu_src_o(src_0), .reg_wr_o(rw_0),
      .uncond_o(un_0), .fn_code_o(fn_0), .result_o(res_0), .zero_o(z_0));

   mdec_ctl_alu_unit #(.DATA_W(W), .SHARED_ADDER(1'b0)) u_dut_sep (
      .opcode_i(opc), .opnd_a_i(a), .opnd_b_i(b),
      .reg2loc_o(r2l_1), .branch_o(br_1), .mem_rd_o(mrd_1), .mem_to_reg_o(m2r_1),
      .alu_op_o(aop_1), .mem_wr_o(mwr_1), .alu_src_o(src_1), .reg_wr_o(rw_1),
      .uncond_o(un_1), .fn_code_o(fn_1), .result_o(res_1), .zero_o(z_1));

   // bit order: reg2loc, branch, mem_rd, mem_to_reg, alu_op[1:0], mem_wr, alu_src, reg_wr, uncond
   function automatic logic [9:0] exp_ctl(input logic [3:0] o);
      case (o)
         4'd0, 4'd1, 4'd2, 4'd3: return 10'b0000_10_0010;   // R1
         4'd6:                   return 10'b0011_00_0110;   // R2 load
         4'd7:                   return 10'b1001_00_1110;   // R2 store
         4'd4, 4'd5:             return 10'b0000_10_0110;   // R3
         4'd8:                   return 10'b1100_01_0100;   // R4 CBZ
         4'd9:                   return 10'b0100_01_0101;   // R4 B
         default:                return 10'b0;              // R5
      endcase
   endfunction

   function automatic string ctl_req(input logic [3:0] o);
      if (o <= 4'd3) return "R1";
      if (o == 4'd6 || o == 4'd7) return "R2";
      if (o == 4'd4 || o == 4'd5) return "R3";
      if (o == 4'd8 || o == 4'd9) return "R4";
      return "R5";
   endfunction

   function automatic logic [2:0] exp_fn(input logic [3:0] o);
      case (o)
         4'd1, 4'd5: return 3'd1;
         4'd2:       return 3'd4;
         4'd3:       return 3'd5;
         4'd8:       return 3'd3;
         4'd9:       return 3'd2;
         default:    return 3'd0;
      endcase
   endfunction

   function automatic logic [W-1:0] exp_res(input logic [2:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
      case (f)
         3'd0: return x + y;
         3'd1: return x - y;
         3'd2: return x;
         3'd4: return x & y;
         3'd5: return x | y;
         default: return '0;
      endcase
   endfunction

   function automatic string res_req(input logic [2:0] f);
      if (f <= 3'd1) return "R7";
      if (f == 3'd3) return "R9";
      return "R8";
   endfunction

   task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s opc=%0d actual=%h expected=%h", req, what, opc, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [2:0] ef;
      @(negedge clk);
      opc = o; a = x; b = y;
      #1;
      ef = exp_fn(o);
      chk(ctl_req(o), "ctl", W'({r2l_0, br_0, mrd_0, m2r_0, aop_0, mwr_0, src_0, rw_0, un_0}), W'(exp_ctl(o)));
      chk(ctl_req(o), "ctl_sep", W'({r2l_1, br_1, mrd_1, m2r_1, aop_1, mwr_1, src_1, rw_1, un_1}), W'(exp_ctl(o)));
      chk((o >= 4'd10) ? "R5" : "R6", "fn", W'(fn_0), W'(ef));
      chk((o >= 4'd10) ? "R5" : "R6", "fn_sep", W'(fn_1), W'(ef));
      chk(res_req(ef), "result", res_0, exp_res(ef, x, y));
      chk(res_req(ef), "result_sep", res_1, exp_res(ef, x, y));
      chk((ef == 3'd3) ? "R9" : "R10", "zero", W'(z_0), W'((ef == 3'd3) && (x == '0)));
      chk((ef == 3'd3) ? "R9" : "R10", "zero_sep", W'(z_1), W'((ef == 3'd3) && (x == '0)));
   endtask

   initial begin
      opc = '0; a = '0; b = '0;
      void'($urandom(32'h5eed_0042));
      // initial state: opcode 0 with zero operands
      apply(4'd0, '0, '0);
      // R7 wrap cases
      apply(4'd0, '1, 64'd1);
      apply(4'd4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
      apply(4'd1, '0, 64'd1);
      apply(4'd5, 64'd5, 64'd7);
      // R8 logic and pass
      apply(4'd2, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF);
      apply(4'd3, 64'hF000_0000_0000_0001, 64'h0000_0000_0000_0100);
      apply(4'd9, 64'hDEAD_BEEF_0BAD_F00D, 64'h1);
      // R9 zero test, both outcomes
      apply(4'd8, '0, 64'h55);
      apply(4'd8, 64'h1, '0);
      apply(4'd8, 64'h8000_0000_0000_0000, '0);
      // R2 memory address add
      apply(4'd6, 64'h100, 64'h8);
      apply(4'd7, 64'h200, 64'h10);
      // R5 every unused opcode, with zero operand a (R10 zero flag stays 0)
      for (int k = 10; k < 16; k++) apply(4'(k), '0, 64'h3);
      // random mix over all opcodes
      for (int n = 0; n < 2000; n++) begin
         logic [W-1:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         if (($urandom % 8) == 0) ra = '0;
         apply(4'($urandom % 16), ra, rb);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule